// File: doc/BRIEF.md
# Auxiliary Conversion Scheduler

This block looks after five 12-bit measurement registers for voltage and temperature readings. It takes their conversions from the receive-path ADC, which it shares with the receive burst path. A host names a register on a small request port. The block answers in the next cycle with what that register holds now, which is the result of an earlier conversion. At the same time it raises a pending flag for that register, so a fresh conversion is owed.

A scheduler watches the pending flags together with the receive-burst and transmit-slot signals. When a pending register may be converted, the scheduler powers up the receive path and steers the input multiplexer to the matching channel. It then holds both for a settling interval that software can set. In the last cycle of that interval it stores the ADC sample and clears the flag. If a receive burst starts during the interval, the conversion is dropped and retried later. Register 0 holds the battery voltage taken during a transmit slot. Register 1 holds the same input taken outside transmit slots.

Top module: `aux_conv_sched`

## Requirements
- R1: Five result registers, 12 bits wide, are addressed 0 to 4 and reset to zero. Addresses 0 and 1 both belong to input channel 0. Addresses 2, 3 and 4 belong to channels 1, 2 and 3.
- R2: A request with `req_valid` high loads the addressed register's present contents onto `rd_data` at the next clock edge. This is the value from before any conversion that the request triggers.
- R3: A request for address 0 to 4 sets bit `req_addr` of `pend_flags` at the next edge. The bit stays set until that register is written.
- R4: A request for address 5, 6 or 7 puts zero on `rd_data` and sets no flag.
- R5: A conversion starts only in a cycle where `rx_active` is low. If `rx_active` is high in a cycle, `rxpath_pwr` is low in the next cycle.
- R6: Register 0 starts converting only when `tx_slot` is high. Register 1 starts only when `tx_slot` is low. Registers 2 to 4 ignore `tx_slot`.
- R7: During a conversion `rxpath_pwr` is high and `mux_sel` holds the channel of the register being converted, without change.
- R8: `rxpath_pwr` stays high for exactly `settle_len` cycles. When `settle_len` is 0, it stays high for 64 cycles. The value of `adc_data` in the last of those cycles is stored, and the flag clears at the same edge.
- R9: If `rx_active` goes high during settling, the conversion stops at once. Nothing is stored, the flag stays set, and the register is converted later.
- R10: When several registers are pending and eligible, the lowest address is converted first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request strobe |
| req_addr | input | 3 | Register address of the request |
| rd_data | output | 12 | Contents returned for the last request |
| pend_flags | output | 5 | One pending-conversion flag per register |
| rx_active | input | 1 | Receive burst in progress |
| tx_slot | input | 1 | Current slot is a transmit slot |
| settle_len | input | 8 | Settling cycles, 0 selects the default |
| adc_data | input | 12 | Sample from the shared ADC |
| rxpath_pwr | output | 1 | Receive path power-up request |
| mux_sel | output | 2 | Input multiplexer channel |

## Verification
A vector table sends requests to every register under both slot states and with varied ADC samples. A returned value that equals the previous sample shows stale-read behaviour, and one that equals the new sample shows the timing is wrong. Directed sequences hold `rx_active` or the wrong slot state and confirm that the flag stays pending with the path unpowered. A burst raised mid-settle separates a clean abort from a partial store. Three flags released at the same moment expose the service order through `mux_sel`. The length of the power pulse is counted for both an explicit and the default settling length.

// File: rtl/aux_sched_pkg.sv
package aux_sched_pkg;

    localparam int NREG = 5;
    localparam int AW   = 3;
    localparam int IW   = 3;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_SETTLE = 1'b1
    } sched_st_e;

    // register index -> multiplexer channel
    function automatic logic [1:0] chan_of(input logic [IW-1:0] idx);
        logic [1:0] ch;
        case (idx)
            3'd0, 3'd1: ch = 2'd0;
            3'd2:       ch = 2'd1;
            3'd3:       ch = 2'd2;
            default:    ch = 2'd3;
        endcase
        return ch;
    endfunction

endpackage

// File: rtl/aux_pick.sv
module aux_pick
    import aux_sched_pkg::*;
(
    input  logic [NREG-1:0] flags,
    input  logic            rx_active,
    input  logic            tx_slot,
    output logic            gnt_vld,
    output logic [IW-1:0]   gnt_idx
);

    logic [NREG-1:0] elig;

    for (genvar g = 0; g < NREG; g++) begin : g_elig
        if (g == 0) begin : g_txreg
            assign elig[g] = flags[g] & ~rx_active & tx_slot;
        end else if (g == 1) begin : g_othreg
            assign elig[g] = flags[g] & ~rx_active & ~tx_slot;
        end else begin : g_anyreg
            assign elig[g] = flags[g] & ~rx_active;
        end
    end

    always_comb begin
        gnt_idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (elig[i]) gnt_idx = IW'(i);
        end
        gnt_vld = |elig;
    end

endmodule

// File: rtl/aux_settle_ctr.sv
module aux_settle_ctr #(
    parameter int CNT_W       = 8,
    parameter int SETTLE_DFLT = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [CNT_W-1:0] len,
    output logic             last
);

    localparam logic [CNT_W-1:0] DFLT_V = CNT_W'(SETTLE_DFLT);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = (len == '0) ? DFLT_V : len;
        end else if (run && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/aux_req_port.sv
module aux_req_port
    import aux_sched_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [AW-1:0]             req_addr,
    input  logic [NREG-1:0][DW-1:0]   results,
    input  logic [NREG-1:0]           clr_vec,
    output logic [DW-1:0]             rd_data,
    output logic [NREG-1:0]           flags
);

    typedef struct packed {
        logic [DW-1:0]   rd;
        logic [NREG-1:0] flg;
    } port_s;

    port_s cur_q, nxt_d;
    logic            addr_ok;
    logic [NREG-1:0] set_vec;

    always_comb begin
        addr_ok = (int'(req_addr) < NREG);
        set_vec = '0;
        nxt_d   = cur_q;
        if (req_valid && addr_ok) begin
            set_vec[req_addr] = 1'b1;
        end
        if (req_valid) begin
            nxt_d.rd = addr_ok ? results[req_addr] : '0;
        end
        // a new request wins over a clear in the same cycle
        nxt_d.flg = (cur_q.flg & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign rd_data = cur_q.rd;
    assign flags   = cur_q.flg;

endmodule

// File: rtl/aux_conv_sched.sv
module aux_conv_sched
    import aux_sched_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int CNT_W       = 8,
    parameter int SETTLE_DFLT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NREG-1:0]   pend_flags,
    input  logic              rx_active,
    input  logic              tx_slot,
    input  logic [CNT_W-1:0]  settle_len,
    input  logic [DATA_W-1:0] adc_data,
    output logic              rxpath_pwr,
    output logic [1:0]        mux_sel
);

    typedef struct packed {
        sched_st_e                     st;
        logic [IW-1:0]                 idx;
        logic [NREG-1:0][DATA_W-1:0]   res;
    } core_s;

    core_s           cur_q, nxt_d;
    logic [NREG-1:0] clr_vec;
    logic            load;
    logic            last;
    logic            gnt_vld;
    logic [IW-1:0]   gnt_idx;

    aux_pick u_pick (
        .flags     (pend_flags),
        .rx_active (rx_active),
        .tx_slot   (tx_slot),
        .gnt_vld   (gnt_vld),
        .gnt_idx   (gnt_idx)
    );

    aux_settle_ctr #(
        .CNT_W       (CNT_W),
        .SETTLE_DFLT (SETTLE_DFLT)
    ) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .run   (cur_q.st == ST_SETTLE),
        .len   (settle_len),
        .last  (last)
    );

    aux_req_port #(
        .DW (DATA_W)
    ) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .results   (cur_q.res),
        .clr_vec   (clr_vec),
        .rd_data   (rd_data),
        .flags     (pend_flags)
    );

    always_comb begin
        nxt_d   = cur_q;
        clr_vec = '0;
        load    = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (gnt_vld) begin
                    nxt_d.st  = ST_SETTLE;
                    nxt_d.idx = gnt_idx;
                    load      = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (rx_active) begin
                    nxt_d.st = ST_IDLE;
                end else if (last) begin
                    nxt_d.res[cur_q.idx] = adc_data;
                    clr_vec[cur_q.idx]   = 1'b1;
                    nxt_d.st             = ST_IDLE;
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st  <= ST_IDLE;
            cur_q.idx <= '0;
            cur_q.res <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign rxpath_pwr = (cur_q.st == ST_SETTLE);
    assign mux_sel    = chan_of(cur_q.idx);

endmodule

// File: rtl/aux_sched_chk.sv
module aux_sched_chk
    import aux_sched_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [AW-1:0]   req_addr,
    input logic [NREG-1:0] pend_flags,
    input logic            rx_active,
    input logic            rxpath_pwr,
    input logic [1:0]      mux_sel
);

    // R3
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && int'(req_addr) < NREG)
            |=> |(pend_flags & (NREG'(1) << $past(req_addr))));

    // R4
    bad_addr_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && int'(req_addr) >= NREG)
            |=> ($countones(pend_flags) <= $countones($past(pend_flags))));

    // R5
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rxpath_pwr) |-> !$past(rx_active));

    // R5
    burst_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_active |=> !rxpath_pwr);

    // R7
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rxpath_pwr && $past(rxpath_pwr)) |-> $stable(mux_sel));

    // R7
    pwr_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rxpath_pwr |-> (pend_flags != '0));

endmodule

bind aux_conv_sched aux_sched_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .pend_flags (pend_flags),
    .rx_active  (rx_active),
    .rxpath_pwr (rxpath_pwr),
    .mux_sel    (mux_sel)
);

// File: tb/sim_aux_conv_sched.sv
`timescale 1ns/1ps
module sim_aux_conv_sched;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [11:0] rd_data;
    logic [4:0]  pend_flags;
    logic        rx_active = 1'b0;
    logic        tx_slot = 1'b0;
    logic [7:0]  settle_len = 8'd4;
    logic [11:0] adc_data = '0;
    logic        rxpath_pwr;
    logic [1:0]  mux_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    aux_conv_sched u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .rd_data    (rd_data),
        .pend_flags (pend_flags),
        .rx_active  (rx_active),
        .tx_slot    (tx_slot),
        .settle_len (settle_len),
        .adc_data   (adc_data),
        .rxpath_pwr (rxpath_pwr),
        .mux_sel    (mux_sel)
    );

    // {addr, tx_slot, adc sample, expected returned value}
    localparam logic [27:0] VEC [8] = '{
        {3'd2, 1'b0, 12'h123, 12'h000},
        {3'd2, 1'b0, 12'h456, 12'h123},
        {3'd0, 1'b1, 12'hA5A, 12'h000},
        {3'd1, 1'b0, 12'h3C3, 12'h000},
        {3'd4, 1'b0, 12'hFFF, 12'h000},
        {3'd3, 1'b1, 12'h001, 12'h000},
        {3'd0, 1'b1, 12'h777, 12'hA5A},
        {3'd4, 1'b1, 12'h800, 12'hFFF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_req(input logic [2:0] a);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_clear(input int idx, input int maxc, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < maxc; i++) begin
            if (!pend_flags[idx]) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic count_pwr(input int idx, output int n);
        n = 0;
        for (int i = 0; i < 400 && pend_flags[idx]; i++) begin
            if (rxpath_pwr) n++;
            @(negedge clk);
        end
    endtask

    initial begin
        bit ok;
        int n;
        logic [1:0] seen [3];
        int k;
        bit prev;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset flags", pend_flags, 0);
        check("R1 reset pwr", rxpath_pwr, 0);
        check("R1 reset rd_data", rd_data, 0);
        rst_n = 1'b1;

        // table walk, settle 4, no burst
        for (int v = 0; v < 8; v++) begin
            tx_slot  = VEC[v][24];
            adc_data = VEC[v][23:12];
            do_req(VEC[v][27:25]);
            check("R2 stale read", rd_data, VEC[v][11:0]);
            check("R3 flag set", pend_flags[VEC[v][27:25]], 1);
            wait_clear(int'(VEC[v][27:25]), 40, ok);
            check("R8 conversion done", ok, 1);
        end

        // R1 read-back of all five registers
        adc_data = 12'h321;
        tx_slot  = 1'b0;
        do_req(3'd0); check("R1 reg0", rd_data, 12'h777);
        do_req(3'd1); check("R1 reg1", rd_data, 12'h3C3);
        do_req(3'd2); check("R1 reg2", rd_data, 12'h456);
        do_req(3'd3); check("R1 reg3", rd_data, 12'h001);
        do_req(3'd4); check("R1 reg4", rd_data, 12'h800);
        repeat (40) @(negedge clk);
        check("R6 reg0 waits for tx slot", pend_flags, 5'b00001);
        tx_slot = 1'b1;
        wait_clear(0, 40, ok);
        check("R6 reg0 done in tx slot", ok, 1);
        tx_slot = 1'b0;

        // R4 invalid addresses
        for (int a = 5; a < 8; a++) begin
            do_req(3'(a));
            check("R4 invalid rd_data", rd_data, 0);
            check("R4 invalid no flag", pend_flags, 0);
        end
        repeat (5) @(negedge clk);
        check("R4 no conversion", rxpath_pwr, 0);

        // R5 burst gating
        rx_active = 1'b1;
        do_req(3'd2);
        k = 0;
        for (int i = 0; i < 20; i++) begin
            if (rxpath_pwr) k++;
            @(negedge clk);
        end
        check("R5 no power during burst", k, 0);
        check("R5 flag held", pend_flags[2], 1);
        rx_active = 1'b0;
        wait_clear(2, 40, ok);
        check("R5 runs after burst", ok, 1);

        // R6 register 1 blocked in tx slot
        tx_slot = 1'b1;
        do_req(3'd1);
        repeat (20) @(negedge clk);
        check("R6 reg1 held in tx slot", pend_flags[1], 1);
        check("R6 reg1 no power", rxpath_pwr, 0);
        tx_slot = 1'b0;
        wait_clear(1, 40, ok);
        check("R6 reg1 done outside tx", ok, 1);

        // R10 ordering and R7 channel select
        rx_active = 1'b1;
        do_req(3'd4);
        do_req(3'd2);
        do_req(3'd3);
        rx_active = 1'b0;
        k = 0;
        prev = 1'b0;
        for (int i = 0; i < 80 && k < 3; i++) begin
            @(negedge clk);
            if (rxpath_pwr && !prev) begin
                seen[k] = mux_sel;
                k++;
            end
            prev = rxpath_pwr;
        end
        check("R10 three services", k, 3);
        check("R10 R7 first channel", seen[0], 1);
        check("R10 R7 second channel", seen[1], 2);
        check("R10 R7 third channel", seen[2], 3);
        repeat (10) @(negedge clk);
        check("R10 all served", pend_flags, 0);

        // R9 abort mid-settle
        settle_len = 8'd10;
        adc_data   = 12'h0AA;
        do_req(3'd3);
        for (int i = 0; i < 10 && !rxpath_pwr; i++) @(negedge clk);
        check("R7 power on for reg3", rxpath_pwr, 1);
        check("R7 reg3 channel", mux_sel, 2);
        repeat (3) @(negedge clk);
        rx_active = 1'b1;
        @(negedge clk);
        check("R9 power dropped", rxpath_pwr, 0);
        check("R9 flag kept", pend_flags[3], 1);
        do_req(3'd3);
        check("R9 nothing stored", rd_data, 12'h321);
        adc_data  = 12'h0BB;
        rx_active = 1'b0;
        wait_clear(3, 40, ok);
        check("R9 retried", ok, 1);
        do_req(3'd3);
        check("R9 retry value", rd_data, 12'h0BB);
        wait_clear(3, 40, ok);

        // R8 settle length
        settle_len = 8'd6;
        do_req(3'd2);
        count_pwr(2, n);
        check("R8 explicit length", n, 6);
        settle_len = 8'd0;
        adc_data   = 12'h5E5;
        do_req(3'd2);
        count_pwr(2, n);
        check("R8 default length", n, 64);
        do_req(3'd2);
        check("R8 last sample stored", rd_data, 12'h5E5);
        wait_clear(2, 100, ok);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule